// File: doc/BRIEF.md
# Byte-Level Two-Wire Bus Master

This block is a master for a two-wire serial bus that works one byte at a time. Software talks to it through three write-selected registers: a control register, a data register and an interrupt/override register. Setting control bits asks the engine to place a START (or repeated START) on the bus, to move one address or data byte with its acknowledge bit, or to place a STOP.

After each START and each byte, the engine raises an event flag and shows a numeric status code. Software reads the code, loads the next byte and then writes the control register to clear the flag and launch the next step. For each received byte, software chooses whether the master acknowledges it. The bit-rate timebase comes in as a `tick` pulse, and every bus bit takes four ticks. Both lines are open-drain: an output of 1 pulls the line low. Two override bits let software pull either line low directly, so it can clock a stuck slave free and then produce a STOP by hand.

Top module: `twm_engine`

## Requirements
- R1: After reset, `ctl_q` is 0x00, `stat_q` is 0xF8, `irq` is 0 and neither line is pulled low.
- R2: Register writes use `wr_sel` 0 for data, 1 for control and 2 for interrupt/override. Writing control with bit 6 (enable) and bit 5 (start) set from idle pulls SDA low while SCL is released, and then pulls SCL low. The event flag then sets with status 0x08. The START takes exactly 4 ticks.
- R3: A start request from idle while SDA reads low does nothing: status stays 0xF8, the flag stays clear and SCL is not pulled.
- R4: A start request while a transfer is active first releases SDA and then SCL, and then produces a START. The resulting status is 0x10.
- R5: The first byte after a START is taken from the data register. That byte is the 7-bit target shifted left by one, with bit 0 set to 1 for read. It is sent MSB first. The status after it is 0x18 or 0x20 for a write that was ACKed or NACKed, and 0x40 or 0x48 for a read that was ACKed or NACKed.
- R6: In write mode, each launched byte sends the data register MSB first. The status is 0x28 when the byte is ACKed and 0x30 when it is NACKed.
- R7: In read mode, a launched byte shifts in 8 bits MSB first into the data register. The master drives ACK (low) in the ninth bit only if control bit 2 was set at launch, and the status is then 0x50. Otherwise it leaves the ninth bit high, and the status is 0x58.
- R8: A control write with the enable bit set clears the event flag. A control write with the enable bit clear launches nothing and leaves the flag set. A control write that arrives while a START, byte or STOP is in progress is ignored.
- R9: A stop request while active pulls SDA low, releases SCL and then releases SDA. After this the bus is idle, the status is 0xF8 and the flag stays clear.
- R10: `irq` is high when bit 6 of the interrupt register is set and the status is not 0xF8.
- R11: Bit 9 of the interrupt register pulls SCL low and bit 8 pulls SDA low, regardless of what the engine is doing.
- R12: Control readback has CE at bit 7, enable at bit 6, start pending at bit 5, stop pending at bit 4, event flag at bit 3 and ack-enable at bit 2. A byte takes exactly 36 ticks, and the line drivers change only on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Quarter-bit timebase pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 data, 1 control, 2 interrupt/override |
| wr_data | input | 10 | Write data (control/data use bits 7:0) |
| sda_in | input | 1 | Sensed SDA level |
| ctl_q | output | 8 | Control register readback |
| dat_q | output | 8 | Data register readback |
| stat_q | output | 8 | Status code |
| irq | output | 1 | Event interrupt |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest situation to reach is a repeated START that follows a read, which must leave the bus with SDA free. This only works if the last byte read was NACKed and the slave then releases the bus. The bench uses a behavioral slave that follows SCL and SDA edges. It runs random chains of reads and writes that end either in a STOP or in a repeated START, with random address and data acknowledges. Directed cases cover a stuck-low SDA, a control write during a byte, and the line overrides.

// File: rtl/twm_engine.sv
module twm_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [9:0] wr_data,
  input  logic       sda_in,
  output logic [7:0] ctl_q,
  output logic [7:0] dat_q,
  output logic [7:0] stat_q,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_XFER, S_STOP, S_WAIT} st_t;

  st_t        st;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic [7:0] sh, dat, code;
  logic       iflg, ce, enab, sta, stp, aak;
  logic       active, rstart, addr_next, rd_mode, cur_rx, cur_addr, ack_ok;
  logic       ie, ovr_scl, ovr_sda, scl_lo, sda_lo;

  wire ctl_ok   = wr_en && wr_sel == 2'd1 && (st == S_IDLE || st == S_WAIT);
  wire last_bit = bitn == 4'd8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; sh <= '0; dat <= '0; code <= 8'hF8;
      iflg <= 1'b0; ce <= 1'b0; enab <= 1'b0; sta <= 1'b0; stp <= 1'b0; aak <= 1'b0;
      active <= 1'b0; rstart <= 1'b0; addr_next <= 1'b0; rd_mode <= 1'b0;
      cur_rx <= 1'b0; cur_addr <= 1'b0; ack_ok <= 1'b0;
      ie <= 1'b0; ovr_scl <= 1'b0; ovr_sda <= 1'b0; scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      if (wr_en && wr_sel == 2'd0) dat <= wr_data[7:0];
      if (wr_en && wr_sel == 2'd2) begin
        ovr_scl <= wr_data[9];
        ovr_sda <= wr_data[8];
        ie      <= wr_data[6];
      end
      if (ctl_ok) begin
        ce   <= wr_data[7];
        enab <= wr_data[6];
        aak  <= wr_data[2];
        sta  <= 1'b0;
        stp  <= 1'b0;
        if (wr_data[6]) begin
          iflg <= 1'b0;
          if (wr_data[5]) begin
            if (active || sda_in) begin
              st <= S_START; ph <= '0; sta <= 1'b1; rstart <= active;
            end
          end else if (wr_data[4]) begin
            if (active) begin
              st <= S_STOP; ph <= '0; stp <= 1'b1;
            end
          end else if (active) begin
            st <= S_XFER; ph <= '0; bitn <= '0; sh <= dat;
            cur_addr  <= addr_next;
            cur_rx    <= !addr_next && rd_mode;
            addr_next <= 1'b0;
            if (addr_next) rd_mode <= dat[0];
          end
        end
      end else if (tick) begin
        case (st)
          S_START: begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_lo <= 1'b0;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b1;
              default: begin
                scl_lo <= 1'b1; st <= S_WAIT; iflg <= 1'b1; sta <= 1'b0;
                code <= rstart ? 8'h10 : 8'h08;
                active <= 1'b1; addr_next <= 1'b1;
              end
            endcase
          end
          S_XFER: begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_lo <= last_bit ? (cur_rx && aak) : (!cur_rx && !sh[7]);
              2'd1: scl_lo <= 1'b0;
              2'd2: begin
                if (last_bit) ack_ok <= !sda_in;
                else          sh <= {sh[6:0], sda_in};
              end
              default: begin
                scl_lo <= 1'b1;
                if (last_bit) begin
                  st <= S_WAIT; iflg <= 1'b1;
                  if (cur_addr)    code <= rd_mode ? (ack_ok ? 8'h40 : 8'h48)
                                                   : (ack_ok ? 8'h18 : 8'h20);
                  else if (cur_rx) code <= aak ? 8'h50 : 8'h58;
                  else             code <= ack_ok ? 8'h28 : 8'h30;
                  if (cur_rx) dat <= sh;
                end else begin
                  bitn <= bitn + 4'd1;
                end
              end
            endcase
          end
          S_STOP: begin
            case (ph)
              2'd0: begin sda_lo <= 1'b1; ph <= 2'd1; end
              2'd1: begin scl_lo <= 1'b0; ph <= 2'd2; end
              default: begin
                sda_lo <= 1'b0; ph <= '0; st <= S_IDLE; active <= 1'b0; stp <= 1'b0;
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assign ctl_q  = {ce, enab, sta, stp, iflg, aak, 2'b00};
  assign dat_q  = dat;
  assign stat_q = iflg ? code : 8'hF8;
  assign irq    = ie && (stat_q != 8'hF8);
  assign scl_oe = scl_lo || ovr_scl;
  assign sda_oe = sda_lo || ovr_sda;

  AST_START_SDA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && $rose(sda_lo)) |-> !scl_lo); // R2
  AST_REFUSE_LOW_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_ok && wr_data[6] && wr_data[5] && !active && !sda_in) |=> (st == S_IDLE && !iflg)); // R3
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && st == S_XFER) |=> ($stable(aak) && $stable(enab) && $stable(ce))); // R8
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (!scl_lo && !sda_lo && !iflg)); // R9
  AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflg) |-> $past(tick)); // R12
  AST_LINES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(scl_lo) && $stable(sda_lo))); // R12
  AST_CODE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    iflg |-> (stat_q[2:0] == 3'b000 && stat_q != 8'hF8)); // R5

endmodule

// File: tb/twm_engine_bench.sv
module twm_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [9:0] wr_data = '0;
  logic [7:0] ctl_q, dat_q, stat_q;
  logic irq, scl_oe, sda_oe, sda_in;

  logic drv = 1'b0, stuck = 1'b0;
  logic ack_addr = 1'b1, ack_data = 1'b1;
  logic [7:0] rd_seed = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  twm_engine u_twm_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sda_in(sda_in), .ctl_q(ctl_q), .dat_q(dat_q),
    .stat_q(stat_q), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe));

  assign sda_in = !(sda_oe || drv || stuck);
  wire scl_b = !scl_oe;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick <= (cyc % 4 == 3);
  end

  function automatic logic [7:0] tx_byte(input int b);
    return rd_seed ^ 8'(b * 29);
  endfunction

  function automatic logic [7:0] addr_code(input logic rd, input logic ack);
    return rd ? (ack ? 8'h40 : 8'h48) : (ack ? 8'h18 : 8'h20);
  endfunction

  function automatic logic [7:0] wdat_code(input logic ack);
    return ack ? 8'h28 : 8'h30;
  endfunction

  function automatic logic [7:0] rdat_code(input logic ak);
    return ak ? 8'h50 : 8'h58;
  endfunction

  // behavioral slave
  int cnt = 0, bidx = 0;
  logic p_scl = 1'b1, p_sda = 1'b1, is_read = 1'b0, addr_ok = 1'b0, rd_done = 1'b0;
  logic [7:0] rxsh = '0, addr_byte = '0, wr_byte = '0;
  logic mack = 1'b0, saw_start = 1'b0, saw_stop = 1'b0;

  always @(negedge clk) begin
    logic [7:0] tb;
    if (p_scl && scl_b && p_sda && !sda_in) begin
      cnt = 0; bidx = 0; rd_done = 0; addr_ok = 0; drv = 0; saw_start = 1;
    end else if (p_scl && scl_b && !p_sda && sda_in) begin
      cnt = 0; bidx = 0; rd_done = 0; addr_ok = 0; drv = 0; saw_stop = 1;
    end else if (!p_scl && scl_b) begin
      if (cnt < 8) rxsh = {rxsh[6:0], sda_in};
      else if (bidx == 0) addr_byte = rxsh;
      else if (!is_read) wr_byte = rxsh;
      else begin mack = sda_in; if (sda_in) rd_done = 1; end
      cnt = cnt + 1;
    end else if (p_scl && !scl_b) begin
      if (cnt == 9) begin
        cnt = 0;
        if (bidx == 0) begin is_read = rxsh[0]; addr_ok = ack_addr; end
        bidx = bidx + 1;
      end
      tb = tx_byte(bidx);
      if (cnt == 8) drv = (bidx == 0) ? ack_addr : (is_read ? 1'b0 : ack_data);
      else if (bidx > 0 && is_read && addr_ok && !rd_done) drv = !tb[7 - cnt];
      else drv = 0;
    end
    p_scl = scl_b;
    p_sda = sda_in;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  int nticks;
  task automatic wait_flag(input string req);
    nticks = 0;
    for (int i = 0; i < 3000; i++) begin
      if (ctl_q[3]) return;
      @(posedge clk);
      if (tick) nticks++;
      @(negedge clk);
    end
    check(0, req, 0, 1);
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        check(0, "WATCHDOG", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic rw, aa, ad, ak;
    logic [6:0] a7;
    logic [7:0] d;
    logic active_now;
    int len;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctl_q == 8'h00, "R1 ctl", ctl_q, 0);
    check(stat_q == 8'hF8 && !irq, "R1 stat/irq", stat_q, 8'hF8);
    check(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);

    // R12 readback, R8 enable clear launches nothing
    wr(2'd1, 10'h0A4);
    check(ctl_q == 8'h84, "R12 readback", ctl_q, 8'h84);
    idle_clocks(40);
    check(stat_q == 8'hF8 && !scl_oe, "R8 no launch without enable", stat_q, 8'hF8);

    // R3 stuck SDA
    stuck = 1'b1;
    wr(2'd1, 10'h060);
    idle_clocks(60);
    check(stat_q == 8'hF8 && !ctl_q[3] && !scl_oe, "R3 refused start", stat_q, 8'hF8);
    stuck = 1'b0;
    idle_clocks(4);

    // R2 start with tick count
    saw_start = 1'b0;
    wr(2'd1, 10'h060);
    wait_flag("R2 flag");
    check(stat_q == 8'h08, "R2 status", stat_q, 8'h08);
    check(saw_start && nticks == 4, "R2 start condition/ticks", nticks, 4);
    check(ctl_q[5] == 1'b0 && scl_oe, "R2 start done", ctl_q, 8'h48);

    // R10 irq
    wr(2'd2, 10'h040);
    check(irq == 1'b1, "R10 irq on event", irq, 1);

    // R8 enable-clear write keeps flag
    wr(2'd1, 10'h000);
    idle_clocks(40);
    check(ctl_q[3] && stat_q == 8'h08, "R8 flag held", stat_q, 8'h08);

    // address write, R12 byte length, R8 ignored write mid-byte
    ack_addr = 1'b1; ack_data = 1'b1;
    wr(2'd0, {2'b00, 7'h2A, 1'b0});
    wr(2'd1, 10'h040);
    idle_clocks(30);
    wr(2'd1, 10'h054);
    check(ctl_q[4] == 1'b0 && ctl_q[2] == 1'b0, "R8 busy write ignored", ctl_q, 8'h40);
    wait_flag("R5 flag");
    check(stat_q == 8'h18, "R5 addr write ack", stat_q, 8'h18);
    check(addr_byte == 8'h54, "R5 addr on bus", addr_byte, 8'h54);
    wr(2'd0, 10'h0C3);
    wr(2'd1, 10'h040);
    wait_flag("R6 flag");
    check(nticks == 36, "R12 byte ticks", nticks, 36);
    check(stat_q == 8'h28 && wr_byte == 8'hC3, "R6 data write", wr_byte, 8'hC3);
    // R9 stop
    saw_stop = 1'b0;
    wr(2'd1, 10'h050);
    idle_clocks(30);
    check(stat_q == 8'hF8 && !ctl_q[3] && saw_stop, "R9 stop", stat_q, 8'hF8);
    check(!scl_oe && !sda_oe && !irq, "R9/R10 released", {scl_oe, sda_oe, irq}, 0);
    wr(2'd2, 10'h000);

    // random transactions
    active_now = 1'b0;
    for (int it = 0; it < 24; it++) begin
      a7 = 7'($urandom); rw = 1'($urandom); aa = ($urandom % 4) != 0;
      len = 1 + $urandom % 3; rd_seed = 8'($urandom);
      ack_addr = aa;
      wr(2'd1, 10'h060);
      wait_flag("R2/R4 flag");
      check(stat_q == (active_now ? 8'h10 : 8'h08), active_now ? "R4 repeated start" : "R2 start",
            stat_q, active_now ? 8'h10 : 8'h08);
      wr(2'd0, {2'b00, a7, rw});
      wr(2'd1, 10'h040);
      wait_flag("R5 flag");
      check(stat_q == addr_code(rw, aa), "R5 addr status", stat_q, addr_code(rw, aa));
      check(addr_byte == {a7, rw}, "R5 addr bits", addr_byte, {a7, rw});
      active_now = 1'b1;
      if (aa) begin
        for (int b = 1; b <= len; b++) begin
          if (rw) begin
            ak = (b < len) ? 1'($urandom) : 1'b0;
            if (b < len && !ak) ak = 1'b1;
            wr(2'd1, ak ? 10'h044 : 10'h040);
            wait_flag("R7 flag");
            check(stat_q == rdat_code(ak), "R7 read status", stat_q, rdat_code(ak));
            check(dat_q == tx_byte(b), "R7 read data", dat_q, tx_byte(b));
            check(mack == !ak, "R7 master ack bit", mack, !ak);
          end else begin
            ad = ($urandom % 4) != 0; ack_data = ad; d = 8'($urandom);
            wr(2'd0, {2'b00, d});
            wr(2'd1, 10'h040);
            wait_flag("R6 flag");
            check(stat_q == wdat_code(ad), "R6 write status", stat_q, wdat_code(ad));
            check(wr_byte == d, "R6 write data", wr_byte, d);
          end
        end
      end
      if (!aa || ($urandom % 2) == 0) begin
        saw_stop = 1'b0;
        wr(2'd1, 10'h050);
        idle_clocks(30);
        check(stat_q == 8'hF8 && saw_stop && !scl_oe && !sda_oe, "R9 stop", stat_q, 8'hF8);
        active_now = 1'b0;
      end
    end
    if (active_now) begin
      wr(2'd1, 10'h050);
      idle_clocks(30);
    end

    // R11 override
    wr(2'd2, 10'h200);
    check(scl_oe && !sda_oe, "R11 scl override", {scl_oe, sda_oe}, 2);
    wr(2'd2, 10'h100);
    check(!scl_oe && sda_oe, "R11 sda override", {scl_oe, sda_oe}, 1);
    wr(2'd2, 10'h340);
    check(scl_oe && sda_oe && !irq, "R11/R10 both, idle irq", {scl_oe, sda_oe, irq}, 6);
    wr(2'd2, 10'h000);
    check(!scl_oe && !sda_oe, "R11 released", {scl_oe, sda_oe}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule